// File: doc/BRIEF.md
# Stream-to-Memory Descriptor DMA Channel

This block moves an incoming byte stream into memory buffers described by a linked list of descriptors. Each beat on the input carries up to a parameterised number of bytes, a byte count and an end-of-packet flag. The engine fetches a descriptor, writes stream bytes one at a time from the descriptor's start address upwards, and closes the descriptor once its buffer is full or a packet ends. Closing rewrites the descriptor's end address to the real fill point, marks whether a packet ended there, raises raw interrupt bits, and then either follows the link to the next descriptor or stops when the descriptor carries the last-in-list mark.

A host starts the channel with a one-cycle pulse and the address of the first descriptor. Memory traffic uses one request/acknowledge port that serves descriptor reads, byte writes and descriptor write-back. The input side has a ready signal, and input is refused while the list has ended or while descriptor traffic is in flight. Bytes left in a beat after a buffer fills carry over into the next descriptor.

Top module: `s2m_desc_dma`

## Requirements
- R1: `in_ready` is low whenever `list_end` is high and whenever `mem_req` is high. A beat offered while the list has ended is not taken and causes no memory write.
- R2: Stream bytes are written one per request to the byte address held in the buffer pointer. Byte 0 of a beat is `in_data[7:0]` and is written first. Each write uses the strobe `1 << addr[1:0]` with the byte on that lane. The pointer advances by one per byte and never writes at or beyond the descriptor's end address. `mem_req` and `mem_addr` stay steady until `mem_ack`.
- R3: A descriptor closes as soon as the pointer equals its end address, even when no packet end is pending.
- R4: A beat with `in_eop` set closes the descriptor after its last byte is stored. A beat with count 0 and `in_eop` set closes it at once.
- R5: The descriptor occupies four 32-bit words: +0 link, +4 start, +8 end, +12 flags (bit0 last-in-list, bit1 interrupt request, bit2 packet ended). On close, the current pointer is written to +8 and then the flags word is written to +12.
- R6: Closing a descriptor whose interrupt-request flag is set sets `raw_intr[1:0]`. `raw_intr[2]` is never set.
- R7: Closing on a packet end sets bit2 in the written-back flags word and sets `raw_intr[3]`.
- R8: `intr_event` pulses for one cycle after a write-back only when that close set a `raw_intr` bit that was clear before.
- R9: After a last-in-list close, `list_end` goes high and the engine stops. Otherwise it reads the linked descriptor and reloads the pointer from that descriptor's start word.
- R10: Bytes still held in a beat when a buffer fills are written into the next descriptor's buffer.
- R11: A descriptor whose start equals its end closes right after it is fetched, with no input consumed.
- R12: `raw_intr` bits named in `intr_clr` are cleared in the next cycle.
- R13: After reset, `in_ready`, `mem_req`, `intr_event`, `list_end` and `raw_intr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken while idle |
| start_desc | input | AW | Address of first descriptor |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when valid |
| in_data | input | 8*BEAT_BYTES | Beat bytes, byte 0 in the low lane |
| in_count | input | CW | Number of valid bytes in the beat (0..BEAT_BYTES) |
| in_eop | input | 1 | Beat ends a packet |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane strobes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| intr_clr | input | 4 | Clear mask for raw interrupt bits |
| raw_intr | output | 4 | Raw interrupt bits |
| intr_event | output | 1 | One-cycle pulse when a close raised a new bit |
| list_end | output | 1 | Last-in-list descriptor has been closed |

## Verification
One list is fed full-width beats that fill a short buffer in the middle of a beat. This separates correct carry-over of the leftover bytes from dropping or duplicating them. A packet-ending beat then closes a buffer early, which shows whether the written-back end address is the real fill point. A final beat both fills a buffer exactly and ends a packet on a descriptor that also requests an interrupt, which shows whether the event pulse fires only for newly raised bits. A second list begins with an empty descriptor and ends with a zero-byte packet-end beat, and a beat offered after the list has ended must stay untaken.

// File: rtl/s2m_dma_pkg.sv
// Shared definitions for the stream-to-memory descriptor engine.
package s2m_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE,
        ST_WB_END,
        ST_WB_FLAGS
    } s2m_state_e;

    // Bit positions inside the descriptor flags word.
    localparam int FLAG_LAST   = 0;
    localparam int FLAG_IRQ    = 1;
    localparam int FLAG_PKTEND = 2;

    // Word offsets of descriptor fields (in words).
    localparam logic [1:0] W_LINK  = 2'd0;
    localparam logic [1:0] W_START = 2'd1;
    localparam logic [1:0] W_END   = 2'd2;
    localparam logic [1:0] W_FLAGS = 2'd3;
endpackage

// File: rtl/s2m_beat_hold.sv
// Holding register for one input beat. Bytes leave from the low lane one at a
// time; the remaining count and the packet-end flag survive descriptor changes.
// Assumes load and pop never happen in the same cycle.
module s2m_beat_hold #(
    parameter int BEAT_BYTES = 4,
    localparam int CW = $clog2(BEAT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [8*BEAT_BYTES-1:0] beat_data,
    input  logic [CW-1:0]           beat_count,
    input  logic                    beat_eop,
    input  logic                    pop,
    input  logic                    eop_clr,
    output logic [7:0]              head_byte,
    output logic [CW-1:0]           remaining,
    output logic                    eop_pending
);
    logic [8*BEAT_BYTES-1:0] data_q;

    // Capture a beat, or shift out one byte / retire the packet end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q      <= '0;
            remaining   <= '0;
            eop_pending <= 1'b0;
        end else if (load) begin
            data_q      <= beat_data;
            remaining   <= beat_count;
            eop_pending <= beat_eop;
        end else begin
            if (pop) begin
                data_q    <= data_q >> 8;
                remaining <= remaining - 1'b1;
            end
            if (eop_clr) begin
                eop_pending <= 1'b0;
            end
        end
    end

    assign head_byte = data_q[7:0];
endmodule

// File: rtl/s2m_irq_raw.sv
// Raw interrupt bits. A close ORs in its bits; the event pulse fires only when
// that close raised a bit that was clear. Set wins over a same-cycle clear.
module s2m_irq_raw (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic [3:0] set_bits,
    input  logic [3:0] clr_bits,
    output logic [3:0] raw,
    output logic       event_pulse
);
    logic [3:0] add_bits;
    assign add_bits = set_en ? set_bits : 4'h0;

    // Update raw bits and flag newly raised ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw         <= 4'h0;
            event_pulse <= 1'b0;
        end else begin
            raw         <= (raw & ~clr_bits) | add_bits;
            event_pulse <= |(add_bits & ~raw);
        end
    end
endmodule

// File: rtl/s2m_desc_dma.sv
// Stream-to-memory descriptor DMA channel. Fetches four-word descriptors,
// writes stream bytes into each buffer, closes on full or packet end, writes
// back end address and flags, then follows the link or stops on last-in-list.
// Assumes AW <= 32, word-aligned descriptors, and a memory that holds each
// request until it raises mem_ack for one cycle.
module s2m_desc_dma
    import s2m_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int BEAT_BYTES = 4,
    localparam int CW = $clog2(BEAT_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [AW-1:0]           start_desc,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [8*BEAT_BYTES-1:0] in_data,
    input  logic [CW-1:0]           in_count,
    input  logic                    in_eop,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [31:0]             mem_wdata,
    output logic [3:0]              mem_wstrb,
    input  logic                    mem_ack,
    input  logic [31:0]             mem_rdata,
    input  logic [3:0]              intr_clr,
    output logic [3:0]              raw_intr,
    output logic                    intr_event,
    output logic                    list_end
);
    s2m_state_e    state_q;
    logic [AW-1:0] desc_q, link_q, end_q, ptr_q;
    logic [2:0]    flags_q;
    logic [1:0]    widx_q;
    logic          close_eop_q;

    logic [7:0]    head_byte;
    logic [CW-1:0] remaining;
    logic          eop_pending;

    logic buf_full, beat_empty, do_byte, load, pop, close_now, close_eop, irq_set;
    logic [3:0] irq_bits;

    assign buf_full   = (ptr_q == end_q);
    assign beat_empty = (remaining == '0);
    assign in_ready   = (state_q == ST_WAIT);
    assign load       = in_valid && in_ready;
    assign do_byte    = (state_q == ST_WRITE) && !buf_full && !beat_empty;
    assign pop        = do_byte && mem_ack;
    assign close_now  = (state_q == ST_WRITE) && (buf_full || (beat_empty && eop_pending));
    assign close_eop  = eop_pending && beat_empty;
    assign irq_set    = (state_q == ST_WB_FLAGS) && mem_ack;
    assign irq_bits   = {close_eop_q, 1'b0, flags_q[FLAG_IRQ], flags_q[FLAG_IRQ]};

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 32'h0;
        mem_wstrb = 4'h0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + {{(AW-4){1'b0}}, widx_q, 2'b00};
            end
            ST_WRITE: begin
                mem_req   = do_byte;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = {4{head_byte}};
                mem_wstrb = 4'b0001 << ptr_q[1:0];
            end
            ST_WB_END: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + {{(AW-4){1'b0}}, W_END, 2'b00};
                mem_wdata = 32'(ptr_q);
                mem_wstrb = 4'hF;
            end
            ST_WB_FLAGS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + {{(AW-4){1'b0}}, W_FLAGS, 2'b00};
                mem_wdata = 32'({flags_q[FLAG_PKTEND] | close_eop_q, flags_q[1:0]});
                mem_wstrb = 4'hF;
            end
            default: ;
        endcase
    end

    // Channel sequencing: fetch, accept, write, close, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            desc_q      <= '0;
            link_q      <= '0;
            end_q       <= '0;
            ptr_q       <= '0;
            flags_q     <= '0;
            widx_q      <= '0;
            close_eop_q <= 1'b0;
            list_end    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    desc_q   <= start_desc;
                    widx_q   <= '0;
                    list_end <= 1'b0;
                    state_q  <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    case (widx_q)
                        W_LINK:  link_q  <= mem_rdata[AW-1:0];
                        W_START: ptr_q   <= mem_rdata[AW-1:0];
                        W_END:   end_q   <= mem_rdata[AW-1:0];
                        default: flags_q <= mem_rdata[2:0];
                    endcase
                    widx_q <= widx_q + 1'b1;
                    if (widx_q == W_FLAGS) state_q <= ST_WRITE;
                end
                ST_WAIT: if (load) state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (close_now) begin
                        close_eop_q <= close_eop;
                        state_q     <= ST_WB_END;
                    end else if (beat_empty) begin
                        state_q <= ST_WAIT;
                    end else if (pop) begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_WB_END: if (mem_ack) state_q <= ST_WB_FLAGS;
                ST_WB_FLAGS: if (mem_ack) begin
                    if (flags_q[FLAG_LAST]) begin
                        list_end <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        desc_q  <= link_q;
                        widx_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    s2m_beat_hold #(.BEAT_BYTES(BEAT_BYTES)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .beat_data   (in_data),
        .beat_count  (in_count),
        .beat_eop    (in_eop),
        .pop         (pop),
        .eop_clr     (close_now && close_eop),
        .head_byte   (head_byte),
        .remaining   (remaining),
        .eop_pending (eop_pending)
    );

    s2m_irq_raw u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (irq_set),
        .set_bits    (irq_bits),
        .clr_bits    (intr_clr),
        .raw         (raw_intr),
        .event_pulse (intr_event)
    );
endmodule

// File: rtl/s2m_desc_dma_props.sv
// Protocol and behaviour checks for s2m_desc_dma, attached by bind.
module s2m_desc_dma_props #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          list_end,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_wstrb,
    input logic          mem_ack,
    input logic [AW-1:0] end_q,
    input logic [3:0]    raw_intr,
    input logic          intr_event
);
    // R1: no input taken after the list has ended
    assert_ready_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        list_end |-> !in_ready);

    // R1: no input taken while memory traffic is in flight
    assert_ready_during_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready);

    // R2: a request holds its address and direction until acknowledged
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: byte writes stay below the descriptor end address
    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_wstrb != 4'hF)) |-> (mem_addr < end_q));

    // R6: the unused raw bit never rises
    assert_bit2_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_intr[2]);

    // R8: an event pulse always comes with a changed raw value
    assert_event_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        intr_event |-> (raw_intr != $past(raw_intr)));
endmodule

bind s2m_desc_dma s2m_desc_dma_props #(.AW(AW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .list_end   (list_end),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wstrb  (mem_wstrb),
    .mem_ack    (mem_ack),
    .end_q      (end_q),
    .raw_intr   (raw_intr),
    .intr_event (intr_event)
);

// File: tb/s2m_desc_dma_test.sv
// Scoreboard bench: a requirement model queues the expected memory writes,
// a monitor compares every write the design performs.
module s2m_desc_dma_test;
    localparam int AW = 32;
    localparam int BB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_desc = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_count = '0;
    logic        in_eop = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  intr_clr = '0;
    logic [3:0]  raw_intr;
    logic        intr_event;
    logic        list_end;

    int tests = 0;
    int fails = 0;
    int events_seen = 0;
    int events_exp = 0;

    always #4 clk = ~clk;

    s2m_desc_dma #(.AW(AW), .BEAT_BYTES(BB)) uut (.*);

    // Bench memory with a backdoor for descriptor setup.
    logic [7:0] mem [0:1023];
    logic       bd_we = 1'b0;
    logic [9:0] bd_addr = '0;
    logic [7:0] bd_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_wstrb[l]) mem[{mem_addr[9:2], 2'b00} + 10'(l)] <= mem_wdata[8*l +: 8];
            end else begin
                mem_rdata <= {mem[mem_addr[9:0] + 10'd3], mem[mem_addr[9:0] + 10'd2],
                              mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (bd_we) mem[bd_addr] <= bd_data;
    end

    function automatic logic [31:0] rd_word(input logic [9:0] a);
        return {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    endfunction

    // Scoreboard queues.
    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    logic        exp_byte [$];
    string       exp_tag  [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each acknowledged write against the queue.
    always @(negedge clk) begin
        if (rst_n && intr_event) events_seen++;
        if (rst_n && mem_req && mem_ack && mem_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R1 unexpected write addr", mem_addr, 32'hx);
            end else begin
                logic [31:0] ea, ed;
                logic        eb;
                string       et;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                eb = exp_byte.pop_front();
                et = exp_tag.pop_front();
                check(mem_addr == ea, {et, " addr"}, mem_addr, ea);
                if (eb) begin
                    check(mem_wstrb == (4'b0001 << ea[1:0]), "R2 strobe", {28'h0, mem_wstrb}, 32'(4'b0001 << ea[1:0]));
                    check(mem_wdata[8*ea[1:0] +: 8] == ed[7:0], "R2 byte", {24'h0, mem_wdata[8*ea[1:0] +: 8]}, ed);
                end else begin
                    check(mem_wdata == ed && mem_wstrb == 4'hF, {et, " word"}, mem_wdata, ed);
                end
            end
        end
    end

    // Requirement model of the descriptor list.
    logic [31:0] d_addr [0:3], d_link [0:3], d_start [0:3], d_end [0:3], d_flags [0:3];
    int          m_cur;
    logic [31:0] m_ptr;
    bit          m_done;
    logic [3:0]  m_raw = 4'h0;

    task automatic push_exp(input logic [31:0] a, input logic [31:0] d, input bit b, input string t);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_byte.push_back(b);
        exp_tag.push_back(t);
    endtask

    task automatic model_close(input bit e);
        logic [3:0] nb;
        push_exp(d_addr[m_cur] + 32'd8, m_ptr, 1'b0, "R5 end");
        push_exp(d_addr[m_cur] + 32'd12, d_flags[m_cur] | (e ? 32'd4 : 32'd0), 1'b0, "R7 flags");
        nb = (d_flags[m_cur][1] ? 4'h3 : 4'h0) | (e ? 4'h8 : 4'h0);
        if ((nb & ~m_raw) != 4'h0) events_exp++;
        m_raw = m_raw | nb;
        if (d_flags[m_cur][0]) m_done = 1'b1;
        else begin
            m_cur++;
            m_ptr = d_start[m_cur];
        end
    endtask

    task automatic model_beat(input logic [31:0] data, input int n, input bit e);
        int i = 0;
        forever begin
            if (m_done) break;
            if (m_ptr == d_end[m_cur]) begin
                model_close(e && i == n);
                if (e && i == n) e = 1'b0;
            end else if (i == n) begin
                if (e) begin
                    model_close(1'b1);
                    e = 1'b0;
                end else break;
            end else begin
                push_exp(m_ptr, {24'h0, data[8*i +: 8]}, 1'b1, "R2 data");
                m_ptr++;
                i++;
            end
        end
    endtask

    task automatic bd_word(input logic [9:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bd_we = 1'b1;
            bd_addr = a + 10'(k);
            bd_data = v[8*k +: 8];
        end
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic put_desc(input int k, input logic [31:0] a, input logic [31:0] lk,
                            input logic [31:0] s, input logic [31:0] en, input logic [31:0] f);
        d_addr[k] = a; d_link[k] = lk; d_start[k] = s; d_end[k] = en; d_flags[k] = f;
        bd_word(a[9:0], lk);
        bd_word(a[9:0] + 10'd4, s);
        bd_word(a[9:0] + 10'd8, en);
        bd_word(a[9:0] + 10'd12, f);
    endtask

    task automatic kick(input logic [31:0] a);
        m_cur = 0;
        m_ptr = d_start[0];
        m_done = 1'b0;
        while (!m_done && m_ptr == d_end[m_cur]) model_close(1'b0);
        @(negedge clk);
        start = 1'b1;
        start_desc = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_beat(input logic [31:0] data, input int n, input bit e);
        model_beat(data, n, e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data = data;
        in_count = 3'(n);
        in_eop = e;
        @(negedge clk);
        in_valid = 1'b0;
        in_eop = 1'b0;
    endtask

    task automatic drain;
        for (int i = 0; i < 3000 && exp_addr.size() != 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(exp_addr.size() == 0, "R9 pending writes", 32'(exp_addr.size()), 32'd0);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check(!in_ready && !mem_req && !intr_event && !list_end && raw_intr == 4'h0,
              "R13 reset outputs", {27'h0, in_ready, mem_req, intr_event, list_end, 1'b0}, 32'h0);

        // List A: spill (R10), full close (R3), early packet end (R4), last-in-list (R9).
        put_desc(0, 32'h000, 32'h010, 32'h100, 32'h106, 32'h2);
        put_desc(1, 32'h010, 32'h020, 32'h140, 32'h148, 32'h0);
        put_desc(2, 32'h020, 32'h000, 32'h180, 32'h184, 32'h3);
        @(negedge clk);
        rst_n = 1'b1;
        kick(32'h000);
        send_beat(32'h44332211, 4, 1'b0);
        send_beat(32'h88776655, 4, 1'b0);
        send_beat(32'h00CCBBAA, 3, 1'b1);
        send_beat(32'h04030201, 4, 1'b1);
        drain();

        check(rd_word(10'h008) == 32'h106, "R3 full end word", rd_word(10'h008), 32'h106);
        check(rd_word(10'h018) == 32'h145, "R4 early end word", rd_word(10'h018), 32'h145);
        check({mem[10'h141], mem[10'h140]} == 16'h8877, "R10 spill bytes", {16'h0, mem[10'h141], mem[10'h140]}, 32'h8877);
        check(rd_word(10'h02C) == 32'h7, "R7 flags last", rd_word(10'h02C), 32'h7);
        check(list_end, "R9 list end", {31'h0, list_end}, 32'h1);
        check(raw_intr == m_raw, "R6 raw bits", {28'h0, raw_intr}, {28'h0, m_raw});
        check(events_seen == events_exp, "R8 event count", events_seen, events_exp);

        // R1: beat offered after the list ended is refused
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 32'hDEADBEEF;
        in_count = 3'd4;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(!in_ready, "R1 refused after end", {31'h0, in_ready}, 32'h0);
        end
        in_valid = 1'b0;

        // R12: clear raw bits
        @(negedge clk);
        intr_clr = 4'hB;
        m_raw = 4'h0;
        @(negedge clk);
        intr_clr = 4'h0;
        check(raw_intr == 4'h0, "R12 cleared", {28'h0, raw_intr}, 32'h0);

        // List B: empty descriptor (R11) and zero-byte packet end (R4).
        put_desc(0, 32'h300, 32'h310, 32'h200, 32'h200, 32'h0);
        put_desc(1, 32'h310, 32'h000, 32'h210, 32'h218, 32'h1);
        kick(32'h300);
        send_beat(32'h0, 0, 1'b1);
        drain();
        check(rd_word(10'h308) == 32'h200, "R11 empty end word", rd_word(10'h308), 32'h200);
        check(rd_word(10'h31C) == 32'h5, "R4 zero-byte packet flags", rd_word(10'h31C), 32'h5);
        check(rd_word(10'h318) == 32'h210, "R5 fill point", rd_word(10'h318), 32'h210);
        check(raw_intr == 4'h8, "R7 raw packet bit", {28'h0, raw_intr}, 32'h8);
        check(events_seen == events_exp, "R8 event count B", events_seen, events_exp);
        check(list_end && !in_ready, "R9 stopped", {30'h0, list_end, in_ready}, 32'h2);
        finish_run();
    end
endmodule